// File: doc/BRIEF.md
# Serial Sideband Packet Receiver

This block collects short serial packets that arrive two bits per clock on a single control line (one bit in the even half of a cycle and one in the odd half, presented to the block as a pair of already-split inputs). Each packet is eight bits wide and takes four cycles. The least significant bit comes first, in the even half of the first cycle.

A transaction begins with a one-cycle start pulse. The pulse carries the transaction kind and the number of packets to expect.
- In a random-access transaction, each packet is the 8-bit column address (address bits 10 down to 3) of one octbyte. The block presents it with a one-cycle valid strobe.
- In a sequential transaction, each packet is a control word. The block decodes it as continue or terminate. A terminate ends the transaction early with a one-cycle pulse.

Top module: `sideband_rx`

## Requirements
- R1: After reset, `busy`, `col_valid`, `term_pulse` and `ctrl_err` are 0 and `col_addr` is 0.
- R2: Within a packet, the even input in packet cycle j (j = 0..3) carries word bit 2j and the odd input carries word bit 2j+1. Packet cycle 0 is the first cycle after the start pulse, or the cycle after the previous packet ended. For an address packet, word bit 0 is column address bit 3 and word bit 7 is bit 10.
- R3: In a random-access transaction, `col_valid` is high for exactly one cycle, the cycle after each packet's fourth cycle. It is high once per octbyte, with `col_addr` holding that packet's word. No strobe appears in any other cycle.
- R4: In a sequential transaction, the control word 8'h20 raises `term_pulse` for one cycle, timed like `col_valid`. `busy` falls in the same cycle, and the remaining packets are not decoded.
- R5: In a sequential transaction, the control word 8'h00 means continue. It produces neither `term_pulse` nor `ctrl_err`.
- R6: Any other control word is treated as continue and sets `ctrl_err`. The flag stays set until the next start pulse or reset.
- R7: `busy` is high from the cycle after a start pulse until the cycle after the last of `xfer_len` packets. After that, the serial inputs have no effect on any output.
- R8: A start pulse with `xfer_len` equal to 0 leaves `busy` low and produces no strobe.
- R9: A start pulse during an active transaction restarts packet alignment and the packet count. It also clears `ctrl_err`.
- R10: Address packets never raise `term_pulse` or `ctrl_err`, and control packets never raise `col_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_start | input | 1 | One-cycle start of a transaction |
| xfer_rand | input | 1 | 1 = random-access (address packets), 0 = sequential (control packets) |
| xfer_len | input | CNT_W | Number of packets in the transaction |
| sb_even | input | 1 | Serial bit from the even half-cycle |
| sb_odd | input | 1 | Serial bit from the odd half-cycle |
| busy | output | 1 | Transaction in progress |
| col_valid | output | 1 | Column address strobe, one per octbyte |
| col_addr | output | 8 | Assembled column address bits 10..3 |
| term_pulse | output | 1 | Terminate decoded |
| ctrl_err | output | 1 | Sticky flag for an undefined control word |

## Verification
Random address words with random lengths expose any bit-order or slot-alignment error, because every one of the eight bit positions is exercised with both values. Control packets are drawn with a bias toward 8'h00 and 8'h20, with other values mixed in. This separates clean continue, terminate in the first, middle or last packet, and the sticky error. Directed cases cover a zero-length start, a restart in the middle of a packet, and serial activity after a transaction has ended. Together they show whether the line is correctly ignored outside a transaction and whether the packet alignment restarts.

// File: rtl/sideband_rx.sv
module sideband_rx #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xfer_start,
  input  logic             xfer_rand,
  input  logic [CNT_W-1:0] xfer_len,
  input  logic             sb_even,
  input  logic             sb_odd,
  output logic             busy,
  output logic             col_valid,
  output logic [7:0]       col_addr,
  output logic             term_pulse,
  output logic             ctrl_err
);
  localparam logic [7:0] TERM_WORD = 8'h20;
  localparam logic [7:0] CONT_WORD = 8'h00;

  logic             rand_q;
  logic [CNT_W-1:0] left;
  logic [1:0]       slot;
  logic [5:0]       sh;
  logic [7:0]       word;
  logic             pkt_end;

  assign word    = {sb_odd, sb_even, sh};
  assign pkt_end = busy && (slot == 2'd3);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      rand_q     <= 1'b0;
      left       <= '0;
      slot       <= '0;
      sh         <= '0;
      col_valid  <= 1'b0;
      col_addr   <= '0;
      term_pulse <= 1'b0;
      ctrl_err   <= 1'b0;
    end else begin
      col_valid  <= 1'b0;
      term_pulse <= 1'b0;
      if (xfer_start) begin
        busy     <= (xfer_len != '0);
        rand_q   <= xfer_rand;
        left     <= xfer_len;
        slot     <= '0;
        ctrl_err <= 1'b0;
      end else if (busy) begin
        sh   <= {sb_odd, sb_even, sh[5:2]};
        slot <= slot + 2'd1;
        if (pkt_end) begin
          left <= left - 1'b1;
          if (left == CNT_W'(1)) busy <= 1'b0;
          if (rand_q) begin
            col_valid <= 1'b1;
            col_addr  <= word;
          end else if (word == TERM_WORD) begin
            term_pulse <= 1'b1;
            busy       <= 1'b0;
          end else if (word != CONT_WORD) begin
            ctrl_err <= 1'b1;
          end
        end
      end
    end
  end

  // R3
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid |=> !col_valid);
  // R4
  term_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    term_pulse |-> !busy);
  // R10
  kinds_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(col_valid && (term_pulse || $rose(ctrl_err))));
  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_err && !xfer_start) |=> ctrl_err);
  // R7
  busy_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(xfer_start));
  // R8
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_start && xfer_len == '0) |=> !busy);
endmodule

// File: tb/sideband_rx_tb_top.sv
module sideband_rx_tb_top;
  localparam int CNT_W = 6;
  logic clk = 0, rst_n = 0;
  logic xfer_start = 0, xfer_rand = 0, sb_even = 0, sb_odd = 0;
  logic [CNT_W-1:0] xfer_len = '0;
  logic busy, col_valid, term_pulse, ctrl_err;
  logic [7:0] col_addr;
  int n_chk = 0, n_bad = 0;
  int unsigned seed = 32'd20240607;

  always #4 clk = ~clk;

  sideband_rx #(.CNT_W(CNT_W)) dut_i (.clk, .rst_n, .xfer_start, .xfer_rand, .xfer_len,
    .sb_even, .sb_odd, .busy, .col_valid, .col_addr, .term_pulse, .ctrl_err);

  function automatic bit exp_term(input logic [7:0] w);
    return w == 8'h20;
  endfunction
  function automatic bit exp_err(input logic [7:0] w);
    return w != 8'h00 && w != 8'h20;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic start(input bit rnd, input int len);
    xfer_start = 1; xfer_rand = rnd; xfer_len = CNT_W'(len);
    @(posedge clk); @(negedge clk);
    xfer_start = 0;
  endtask

  task automatic send_pkt(input logic [7:0] w);
    for (int j = 0; j < 4; j++) begin
      sb_even = w[2*j]; sb_odd = w[2*j+1];
      @(posedge clk); @(negedge clk);
      if (j < 3) chk("R3 no strobe mid-packet", {col_valid, term_pulse}, 2'b00);
    end
  endtask

  task automatic run_xfer(input bit rnd, input int len, input int pterm);
    bit err = 0;
    bit done = 0;
    start(rnd, len);
    chk("R7 busy after start", busy, 1);
    for (int p = 0; p < len && !done; p++) begin
      logic [7:0] w;
      int r = $urandom_range(99);
      if (rnd) w = 8'($urandom);
      else if (r < 50) w = 8'h00;
      else if (r < 50 + pterm) w = 8'h20;
      else w = 8'($urandom);
      send_pkt(w);
      if (rnd) begin
        chk("R3 col_valid", col_valid, 1);
        chk("R2 col_addr bit order", col_addr, w);
        chk("R10 addr no term/err", {term_pulse, ctrl_err}, 2'b00);
      end else begin
        err |= exp_err(w);
        chk("R10 ctrl no col_valid", col_valid, 0);
        chk(exp_term(w) ? "R4 term_pulse" : "R5 continue", term_pulse, exp_term(w));
        chk("R6 ctrl_err", ctrl_err, err);
        done = exp_term(w);
      end
      chk("R7 busy", busy, !(done || p == len - 1));
    end
    for (int k = 0; k < 8; k++) begin
      sb_even = 1'($urandom); sb_odd = 1'($urandom);
      @(posedge clk); @(negedge clk);
    end
    chk("R7 idle line ignored", {busy, col_valid, term_pulse, ctrl_err}, {3'b000, err});
  endtask

  initial begin
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    chk("R1 reset state", {busy, col_valid, term_pulse, ctrl_err, col_addr}, 12'h0);
    rst_n = 1;
    @(negedge clk);
    start(1, 0);
    chk("R8 zero length", busy, 0);
    send_pkt(8'hA5);
    chk("R8 no strobe", col_valid, 0);
    // R9: restart mid-packet
    start(0, 3);
    sb_even = 1; sb_odd = 1; @(posedge clk); @(negedge clk);
    start(1, 1);
    send_pkt(8'h3C);
    chk("R9 restart realigns", {col_valid, col_addr}, {1'b1, 8'h3C});
    chk("R9 restart count", busy, 0);
    // R6 clear by new start
    start(0, 2);
    send_pkt(8'h81);
    chk("R6 err set", ctrl_err, 1);
    send_pkt(8'h00);
    chk("R6 err sticky", ctrl_err, 1);
    start(0, 1);
    chk("R9 err cleared", ctrl_err, 0);
    send_pkt(8'h20);
    chk("R4 term last packet", {term_pulse, busy}, 2'b10);
    for (int t = 0; t < 60; t++)
      run_xfer(1'($urandom), $urandom_range(1, 6), 15);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule